// File: doc/BRIEF.md
# Quarter-Rate 800x600 Display Timing Generator

This block generates the raster timing for an 800x600 display from a pixel clock running at one quarter of the native rate (10 MHz instead of 40 MHz). Each clock therefore stands for four native pixels across. This gives 200 visible clocks per line, and each line is 264 clocks long. A horizontal counter walks the columns of a line. It drives the horizontal sync and raises a one-cycle tick on the last clock of each line. A vertical counter moves to the next line only on that tick.

The block outputs active-high horizontal and vertical sync, an active-video flag, and the current column and line numbers. It also gives two single-cycle markers: one at the first clock of vertical blanking and one at the first clock of a new frame. A consumer uses these markers to know when the frame buffer may be written safely. Vertical blanking lasts 28 lines, which is 739.2 microseconds at 26.4 microseconds per line. The only inputs are the clock and a synchronous reset.

Top module: `qsvga_timing`

## Requirements
- R1: The column output counts up by one every clock from 0 to 263 and then returns to 0, so a line is 264 clocks.
- R2: `hsync` is high exactly for columns 210 through 241 inclusive (32 clocks) and low otherwise.
- R3: `line_tick` is high exactly when the column is 263, and the line output changes only on the clock edge that ends such a cycle.
- R4: The line output counts 0 to 627 and returns to 0 after the last clock of line 627, so a frame is 628 lines.
- R5: `vsync` is high exactly for lines 601 through 604 inclusive and low otherwise.
- R6: `active` is high exactly when the column is below 200 and the line is below 600.
- R7: `vbl_begin` is high only in the cycle where the column is 0 and the line is 600, and is never high in two consecutive cycles.
- R8: `vbl_end` is high only in the cycle where the column is 0 and the line is 0. This includes the first cycle after reset is released.
- R9: While `rst` is high at a rising edge, the column and line become 0 at that edge, even in the middle of a line or frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate pixel clock (10 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | High inside the visible 200x600 area |
| col | output | 9 | Current column, 0 to 263 |
| line | output | 10 | Current line, 0 to 627 |
| line_tick | output | 1 | High on the last clock of each line |
| vbl_begin | output | 1 | One-cycle marker at the first clock of line 600 |
| vbl_end | output | 1 | One-cycle marker at the first clock of line 0 |

## Verification
The bench targets the wrap points: column 263 to 0 and line 627 to 0. An off-by-one counter limit would show up there as a 263- or 265-clock line, or a frame one line short or long. It also checks the exact edges of both sync windows and of the active area. A comparison that is off by one shifts the sync by a clock or a line, or lets visible video leak into the porch. The two blanking markers are checked for position and width. A version that decoded only the line number would hold each marker for a whole line. Reset is asserted in the middle of a line, so a counter that ignored reset there would show up at once.

// File: rtl/qsvga_pkg.sv
package qsvga_pkg;

  // True when pos lies in [lo, lo+len)
  function automatic logic in_window(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // Sum of the four segments of a scan period
  function automatic int period_total(input int vis, input int fp, input int syn, input int bp);
    return vis + fp + syn + bp;
  endfunction

  // Index of the first sync position in a period
  function automatic int sync_first(input int vis, input int fp);
    return vis + fp;
  endfunction

endpackage

// File: rtl/qsvga_hgen.sv
module qsvga_hgen
  import qsvga_pkg::*;
#(
  parameter int VIS  = 200,
  parameter int FP   = 10,
  parameter int SYN  = 32,
  parameter int BP   = 22,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] col,
  output logic          hsync,
  output logic          hvis,
  output logic          line_first,
  output logic          line_last
);
  localparam int TOTAL = period_total(VIS, FP, SYN, BP);
  localparam int S_LO  = sync_first(VIS, FP);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign col        = cnt_q;
  assign hsync      = in_window(int'(cnt_q), S_LO, SYN);
  assign hvis       = in_window(int'(cnt_q), 0, VIS);
  assign line_first = (cnt_q == '0);
  assign line_last  = (cnt_q == LAST);

  // R1: the column steps by one inside a line
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R1: the column wraps after the last position
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    line_last |=> line_first);
  // R2: sync never overlaps visible columns
  p_sync_vis_r2: assert property (@(posedge clk) disable iff (rst)
    hsync |-> !hvis);

endmodule

// File: rtl/qsvga_vgen.sv
module qsvga_vgen
  import qsvga_pkg::*;
#(
  parameter int VIS = 600,
  parameter int FP  = 1,
  parameter int SYN = 4,
  parameter int BP  = 23,
  parameter int LW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [LW-1:0] line,
  output logic          vsync,
  output logic          vvis,
  output logic          at_top,
  output logic          at_blank
);
  localparam int TOTAL = period_total(VIS, FP, SYN, BP);
  localparam int S_LO  = sync_first(VIS, FP);
  localparam logic [LW-1:0] LAST  = LW'(TOTAL - 1);
  localparam logic [LW-1:0] BLANK = LW'(VIS);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (adv) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + LW'(1);
    end
  end

  assign line     = cnt_q;
  assign vsync    = in_window(int'(cnt_q), S_LO, SYN);
  assign vvis     = in_window(int'(cnt_q), 0, VIS);
  assign at_top   = (cnt_q == '0);
  assign at_blank = (cnt_q == BLANK);

  // R3: the line holds between ticks
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q));
  // R4: the line steps on a tick below the last line
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + LW'(1)));
  // R4: the frame wraps after the last line
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt_q == LAST) |=> at_top);
  // R5: vertical sync lies inside blanking
  p_vsync_blank_r5: assert property (@(posedge clk) disable iff (rst)
    vsync |-> !vvis);

endmodule

// File: rtl/qsvga_marks.sv
module qsvga_marks (
  input  logic clk,
  input  logic rst,
  input  logic line_first,
  input  logic at_top,
  input  logic at_blank,
  output logic vbl_begin,
  output logic vbl_end
);
  assign vbl_begin = line_first && at_blank;
  assign vbl_end   = line_first && at_top;

  // R7: the start marker is a single cycle wide
  p_begin_once_r7: assert property (@(posedge clk) disable iff (rst)
    vbl_begin |=> !vbl_begin);
  // R8: the end marker is a single cycle wide
  p_end_once_r8: assert property (@(posedge clk) disable iff (rst)
    vbl_end |=> !vbl_end);
  // R7, R8: the two markers never coincide
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(vbl_begin && vbl_end));

endmodule

// File: rtl/qsvga_timing.sv
module qsvga_timing
  import qsvga_pkg::*;
#(
  parameter int H_VIS  = 200,
  parameter int H_FP   = 10,
  parameter int H_SYN  = 32,
  parameter int H_BP   = 22,
  parameter int V_VIS  = 600,
  parameter int V_FP   = 1,
  parameter int V_SYN  = 4,
  parameter int V_BP   = 23,
  localparam int CW = $clog2(period_total(H_VIS, H_FP, H_SYN, H_BP)),
  localparam int LW = $clog2(period_total(V_VIS, V_FP, V_SYN, V_BP))
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync,
  output logic          vsync,
  output logic          active,
  output logic [CW-1:0] col,
  output logic [LW-1:0] line,
  output logic          line_tick,
  output logic          vbl_begin,
  output logic          vbl_end
);
  logic hvis, vvis, line_first, at_top, at_blank;

  qsvga_hgen #(.VIS(H_VIS), .FP(H_FP), .SYN(H_SYN), .BP(H_BP), .CW(CW)) u_h (
    .clk(clk), .rst(rst), .col(col), .hsync(hsync), .hvis(hvis),
    .line_first(line_first), .line_last(line_tick));

  qsvga_vgen #(.VIS(V_VIS), .FP(V_FP), .SYN(V_SYN), .BP(V_BP), .LW(LW)) u_v (
    .clk(clk), .rst(rst), .adv(line_tick), .line(line), .vsync(vsync),
    .vvis(vvis), .at_top(at_top), .at_blank(at_blank));

  qsvga_marks u_m (
    .clk(clk), .rst(rst), .line_first(line_first), .at_top(at_top),
    .at_blank(at_blank), .vbl_begin(vbl_begin), .vbl_end(vbl_end));

  assign active = hvis && vvis;

  // R6: no visible video while either sync is high
  p_active_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (hsync || vsync) |-> !active);
  // R9: reset clears both counters on the next edge
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (col == '0 && line == '0));

endmodule

// File: tb/qsvga_timing_tb.sv
module qsvga_timing_tb_top;
  localparam time TCLK = 100ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync, vsync, active, line_tick, vbl_begin, vbl_end;
  logic [8:0] col;
  logic [9:0] line;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int mh = 0;
  int mv = 0;

  always #(TCLK/2) clk = ~clk;

  qsvga_timing dut_i (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .active(active),
    .col(col), .line(line), .line_tick(line_tick),
    .vbl_begin(vbl_begin), .vbl_end(vbl_end));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s at h=%0d v=%0d: actual %0d expected %0d", req, mh, mv, act, exp);
    end
  endtask

  // Compare every output against the behavioural model
  task automatic compare();
    int e_hs, e_vs, e_act, e_tick, e_b, e_e;
    e_hs   = (mh >= 210 && mh <= 241);
    e_vs   = (mv >= 601 && mv <= 604);
    e_act  = (mh < 200 && mv < 600);
    e_tick = (mh == 263);
    e_b    = (mh == 0 && mv == 600);
    e_e    = (mh == 0 && mv == 0);
    chk(int'(col) == mh, "R1", int'(col), mh);
    chk(int'(line) == mv, "R4", int'(line), mv);
    chk(int'(hsync) == e_hs, "R2", int'(hsync), e_hs);
    chk(int'(vsync) == e_vs, "R5", int'(vsync), e_vs);
    chk(int'(active) == e_act, "R6", int'(active), e_act);
    chk(int'(line_tick) == e_tick, "R3", int'(line_tick), e_tick);
    chk(int'(vbl_begin) == e_b, "R7", int'(vbl_begin), e_b);
    chk(int'(vbl_end) == e_e, "R8", int'(vbl_end), e_e);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      mh = 0; mv = 0;
    end else if (mh == 263) begin
      mh = 0;
      mv = (mv == 627) ? 0 : mv + 1;
    end else begin
      mh = mh + 1;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) step();
    // R9: reset state
    chk(col == 9'd0 && line == 10'd0, "R9", int'(col), 0);
    rst = 1'b0;
    repeat (1500) step();
    // R9: reset in the middle of a line on a nonzero line
    rst = 1'b1;
    step();
    chk(col == 9'd0 && line == 10'd0, "R9", int'(line), 0);
    step();
    rst = 1'b0;
    // one full frame plus margin crosses both wraps and both markers
    repeat (628 * 264 + 400) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule